// File: doc/BRIEF.md
# Shared-Pin Bidirectional GPIO Port

This block owns eight device pins and lends them to one of two users: a general-purpose I/O port, or an external 8-bit system data bus run by a memory interface. A one-bit mode field in a configuration register chooses the user. Out of reset that field selects the external bus, so the pins carry system data until software hands them to the port.

In port mode each pin has a direction bit and an output-latch bit. A direction bit of 1 makes the pin an input with its driver off. A direction bit of 0 makes the pin an output that drives the latch bit. Software reaches the registers over a small internal register bus with an address, a write strobe, a read strobe and byte-wide data. Two addresses return different values. The latch address returns the stored output value, so a read-modify-write acts on the latch. The port address returns the pin level after a two-flop synchronizer. A write to either address loads the same latch.

In bus mode the memory interface alone decides the pad drive data and output enable, and it samples the raw pin levels. The port registers can still be read and written in this mode, so software can set up the latch and direction before it switches the pins over.

Top module: `gpio_busmux_port`

## Requirements
- R1: After reset the latch reads 0x00, the direction register reads 0xFF and the configuration register reads 0x00. A configuration read value of 0x00 means bus mode.
- R2: A write to address 0 (port) or to address 1 (latch) loads the output latch on the clock edge that samples the write strobe. Writing 0x00 to either address clears every latch bit.
- R3: A read of address 1 returns the stored latch value, even when the pins carry a different level.
- R4: A read of address 0 returns the pin level through two flip-flops. A pin change made between two clock edges appears after the second rising edge, not the first. With the read strobe low, read data is 0x00.
- R5: In port mode pad_oe is the bitwise inverse of the direction register, and pad_out equals the latch. After 0xCF is written to the direction register, pad_oe reads 0x30.
- R6: A write to address 2 loads the direction register, and a read of address 2 returns it.
- R7: In bus mode, pad_out equals bus_dout and every bit of pad_oe equals bus_drive, whatever the latch and direction registers hold.
- R8: In bus mode, writes to the latch and direction registers take effect and read back correctly. These values reach the pads once port mode is selected.
- R9: In bus mode, bus_din equals pad_in. In port mode, bus_din is 0x00.
- R10: Address 3 is the configuration register. Bit 0 = 1 selects port mode and bit 0 = 0 selects bus mode. Bits 7:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 configuration |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; also enables the pin sample onto read data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the selected register |
| pad_in | input | 8 | Level present on the pins |
| pad_out | output | 8 | Data driven to the pins |
| pad_oe | output | 8 | Per-pin output enable, 1 = drive |
| bus_dout | input | 8 | Data from the memory interface for the pins |
| bus_drive | input | 1 | Memory interface requests the pins be driven |
| bus_din | output | 8 | Pin levels returned to the memory interface |
| bus_mode | output | 1 | High while the pins belong to the external bus |

## Verification
The hardest case to reach is a port read that catches a pin change between the two synchronizer flops. The bench changes pad_in at a falling edge and reads address 0 after one rising edge and again after the next, expecting the old value and then the new one. A second case needs a setup sequence: registers written during bus mode must stay invisible at the pads, and then appear once port mode is selected. To reach it, the bench forces pad_out and pad_oe away from the latch and direction values while writing them, then flips the mode and checks the pads again.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_PORT  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_CFG   = 2'd3
  } reg_sel_e;

  localparam int unsigned WIDTH = 8;

  // A direction bit of 1 means input, so the driver enable is its inverse.
  function automatic logic [WIDTH-1:0] dir_to_oe(input logic [WIDTH-1:0] dir);
    return ~dir;
  endfunction

  // Writes to the port address and to the latch address share one latch.
  function automatic logic hits_latch(input reg_sel_e sel);
    return (sel == SEL_PORT) || (sel == SEL_LATCH);
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  reg_sel_e     sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic         port_sel_q
);

  logic latch_we;
  logic dir_we;
  logic cfg_we;

  assign latch_we = wr && hits_latch(sel);
  assign dir_we   = wr && (sel == SEL_DIR);
  assign cfg_we   = wr && (sel == SEL_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= '0;
      dir_q      <= '1;
      port_sel_q <= 1'b0;
    end else begin
      if (latch_we) latch_q <= wdata;
      if (dir_we)   dir_q   <= wdata;
      if (cfg_we)   port_sel_q <= wdata[0];
    end
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    latch_we |=> (latch_q == $past(wdata)))
    else $error("latch load"); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_we |=> $stable(latch_q))
    else $error("latch hold"); // R3
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> (dir_q == $past(wdata)))
    else $error("dir load"); // R6

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);

  logic [W-1:0] chain [STAGES+1];
  logic         run_q;

  assign chain[0] = pin_in;
  assign pin_sync = chain[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= '0;
      else        chain[g+1] <= chain[g];
    end

    AST_SYNC_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> (chain[g+1] == $past(chain[g])))
      else $error("sync stage"); // R4
  end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         port_sel,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] bus_dout,
  input  logic         bus_drive,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] bus_din
);

  always_comb begin
    if (port_sel) begin
      pad_out = latch_q;
      pad_oe  = dir_to_oe(dir_q);
      bus_din = '0;
    end else begin
      pad_out = bus_dout;
      pad_oe  = {W{bus_drive}};
      bus_din = pad_in;
    end
  end

endmodule

// File: rtl/gpio_busmux_port.sv
module gpio_busmux_port
  import gpio_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] bus_dout,
  input  logic         bus_drive,
  output logic [W-1:0] bus_din,
  output logic         bus_mode
);

  reg_sel_e     sel;
  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic         port_sel_q;
  logic [W-1:0] pin_sync;

  assign sel      = reg_sel_e'(reg_addr);
  assign bus_mode = !port_sel_q;

  gpio_port_regs #(.W(W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .latch_q    (latch_q),
    .dir_q      (dir_q),
    .port_sel_q (port_sel_q)
  );

  gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pad_in),
    .pin_sync (pin_sync)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .port_sel  (port_sel_q),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .bus_dout  (bus_dout),
    .bus_drive (bus_drive),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .bus_din   (bus_din)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (sel)
        SEL_PORT:  reg_rdata = pin_sync;
        SEL_LATCH: reg_rdata = latch_q;
        SEL_DIR:   reg_rdata = dir_q;
        SEL_CFG:   reg_rdata = {{(W-1){1'b0}}, port_sel_q};
        default:   reg_rdata = '0;
      endcase
    end
  end

  AST_PORT_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> ((pad_oe & dir_q) == '0))
    else $error("input pin driven"); // R5
  AST_BUS_IN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_PORT && port_sel_q) |-> (bus_din == '0))
    else $error("bus input leaks"); // R9

endmodule

// File: tb/gpio_busmux_port_test.sv
module gpio_busmux_port_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic [7:0] bus_dout;
  logic       bus_drive;
  logic [7:0] bus_din;
  logic       bus_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  gpio_busmux_port uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .bus_dout(bus_dout), .bus_drive(bus_drive), .bus_din(bus_din),
    .bus_mode(bus_mode)
  );

  typedef enum int {K_RDATA, K_OE, K_OUT, K_BUSIN, K_MODE} kind_e;
  typedef struct {
    kind_e      kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  event  mon_done;

  // Monitor: pops each expected item and compares with the output it names.
  initial begin
    forever begin
      wait (q.size() != 0);
      #1;
      begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RDATA: act = reg_rdata;
          K_OE:    act = pad_oe;
          K_OUT:   act = pad_out;
          K_BUSIN: act = bus_din;
          default: act = {7'd0, bus_mode};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
        end
      end
      ->mon_done;
    end
  end

  task automatic expect_val(kind_e k, logic [7:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
    @(mon_done);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_expect(logic [1:0] a, logic [7:0] e, string r);
    reg_addr = a; reg_rd = 1'b1;
    expect_val(K_RDATA, e, r);
    reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = 8'h00; pad_in = 8'h00; bus_dout = 8'h00; bus_drive = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_expect(2'd1, 8'h00, "R1 latch reset");
    rd_expect(2'd2, 8'hFF, "R1 dir reset");
    rd_expect(2'd3, 8'h00, "R1 cfg reset bus mode");
    expect_val(K_MODE, 8'h01, "R1 bus_mode after reset");
    expect_val(K_OE, 8'h00, "R7 bus_drive low");

    // R7 bus mode pad control
    bus_drive = 1'b1; bus_dout = 8'hA5;
    expect_val(K_OE, 8'hFF, "R7 bus_drive high");
    expect_val(K_OUT, 8'hA5, "R7 pad_out from bus");

    // R8 writes in bus mode
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'h00);
    bus_drive = 1'b0;
    expect_val(K_OUT, 8'hA5, "R8 latch ignored in bus mode");
    expect_val(K_OE, 8'h00, "R8 dir ignored in bus mode");
    rd_expect(2'd1, 8'h3C, "R8 latch written in bus mode");
    rd_expect(2'd2, 8'h00, "R8 dir written in bus mode");

    // R9 bus sample path
    pad_in = 8'h5A;
    expect_val(K_BUSIN, 8'h5A, "R9 bus_din in bus mode");

    // R10 switch to port mode
    wr(2'd3, 8'h01);
    rd_expect(2'd3, 8'h01, "R10 cfg readback");
    expect_val(K_BUSIN, 8'h00, "R9 bus_din quiet in port mode");
    expect_val(K_OUT, 8'h3C, "R8 latch reaches pad");
    expect_val(K_OE, 8'hFF, "R8 dir reaches pad");
    wr(2'd3, 8'hFF);
    rd_expect(2'd3, 8'h01, "R10 upper cfg bits read zero");

    // R5 / R6 direction pattern
    bus_drive = 1'b1;
    wr(2'd2, 8'hCF);
    rd_expect(2'd2, 8'hCF, "R6 dir readback");
    expect_val(K_OE, 8'h30, "R5 oe from 0xCF");
    expect_val(K_OUT, 8'h3C, "R5 pad_out from latch");

    // R2 write through port address
    wr(2'd0, 8'h96);
    rd_expect(2'd1, 8'h96, "R2 port write loads latch");
    expect_val(K_OUT, 8'h96, "R2 pad_out follows latch");

    // R3 latch read independent of pins
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rd_expect(2'd1, 8'h96, "R3 latch not pin");
    rd_expect(2'd0, 8'h00, "R4 pin read settled");

    // R4 two-stage delay
    pad_in = 8'h81;
    @(negedge clk);
    rd_expect(2'd0, 8'h00, "R4 after one edge");
    @(negedge clk);
    rd_expect(2'd0, 8'h81, "R4 after two edges");
    reg_addr = 2'd1;
    expect_val(K_RDATA, 8'h00, "R4 idle read data");

    // R2 clear via latch address
    wr(2'd1, 8'h00);
    rd_expect(2'd1, 8'h00, "R2 latch cleared");

    // R7 back to bus mode
    wr(2'd3, 8'h00);
    bus_dout = 8'h7E;
    expect_val(K_OUT, 8'h7E, "R7 pad_out bus again");
    expect_val(K_OE, 8'hFF, "R7 oe bus again");
    expect_val(K_MODE, 8'h01, "R10 bus mode restored");

    done = 1;
    finish_run();
  end

endmodule